// File: doc/BRIEF.md
# Nibble-Wide Host Interface Assembler

This block connects a host with a 4-bit data bus to an internal path built for 8-bit registers. Each register write takes two strobed transfers. The upper half of the byte comes first and the lower half second. The block joins the two halves into one byte. It then issues a single-cycle write pulse that carries the byte and a target flag. The flag selects either the instruction register or the data register.

When a byte completes, the block raises a busy flag for a fixed execution window of `GAP_CYCLES` clock cycles. The host can read the flag on bit 3 of the bus, but only while the interface is waiting for an upper half. A host that skips polling must itself keep writes outside the window. If a write strobe arrives while busy is raised, the block sets a sticky protocol-error flag. It still assembles and delivers that write as usual.

Top module: `nib_host_if`

## Requirements
- R1: After reset, `wr_valid_o`, `busy_o` and `proto_err_o` are 0, `wr_data_o` is 0, and the next write strobe is taken as an upper half.
- R2: A write strobe (`strobe_i`=1, `rw_i`=0) in the upper phase, followed by a write strobe in the lower phase, produces exactly one `wr_valid_o` pulse. The pulse lasts one cycle and starts in the cycle after the clock edge that samples the lower strobe. During the pulse, `wr_data_o` = {upper nibble, lower nibble}.
- R3: A lone upper-half write strobe produces no `wr_valid_o` pulse.
- R4: `wr_sel_o` takes the `rs_i` value sampled with the upper half. The encoding is 0 = instruction register and 1 = data register. The `rs_i` value present with the lower half is ignored.
- R5: `busy_o` rises in the same cycle as `wr_valid_o` and stays at 1 for exactly `GAP_CYCLES` (default 10) cycles.
- R6: While `rw_i`=1 and the interface is in the upper phase, `bus_o` = {`busy_o`, 3'b000}. A read strobe does not change the phase.
- R7: While `rw_i`=1 and the interface is in the lower phase, `bus_o` = 4'b0000, and a read strobe does not complete or disturb the pending byte.
- R8: A write strobe sampled while `busy_o`=1 sets `proto_err_o`, which then stays at 1 until reset. The byte written during the violation is still delivered with its correct value.
- R9: A read strobe sampled while `busy_o`=1 leaves `proto_err_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Transfer strobe, one cycle per nibble |
| rs_i | input | 1 | Register select: 0 instruction, 1 data |
| rw_i | input | 1 | 1 = status read, 0 = write |
| bus_i | input | 4 | Nibble from host |
| bus_o | output | 4 | Status nibble to host, busy flag on bit 3 |
| wr_valid_o | output | 1 | One-cycle write pulse to the internal register path |
| wr_sel_o | output | 1 | Target register of the pulse |
| wr_data_o | output | 8 | Assembled byte |
| busy_o | output | 1 | Execution window active |
| proto_err_o | output | 1 | Sticky flag: write strobe seen while busy |

## Verification
Two functions can fall in the same cycle. A lower-half strobe can arrive while busy from the previous byte is still high, so the block must raise the error, reload the busy window and deliver the new byte all at once. The bench provokes this by writing a second byte straight after the first, with no polling. It then checks that the scoreboard still receives both bytes intact, that `proto_err_o` is latched, and that busy runs a fresh full window after the second pulse.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic {
    SEL_INSTR = 1'b0,
    SEL_DATA  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/nib_phase.sv
module nib_phase
  import nib_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic             rs_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             phase_hi_o,
  output logic [NIB_W-1:0] hi_nib_o,
  output reg_sel_e         sel_o,
  output logic             byte_done_o
);
  logic     low_q;
  reg_sel_e sel_q;

  assign phase_hi_o  = !low_q;
  assign byte_done_o = wr_stb_i && low_q;
  assign sel_o       = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q    <= 1'b0;
      hi_nib_o <= '0;
      sel_q    <= SEL_INSTR;
    end else if (wr_stb_i) begin
      low_q <= !low_q;
      if (!low_q) begin
        hi_nib_o <= nib_i;
        sel_q    <= reg_sel_e'(rs_i);
      end
    end
  end

  AST_PHASE_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && low_q) |=> !low_q); // R2
  AST_UPPER_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !low_q) |=> low_q); // R3
endmodule

// File: rtl/nib_gap.sv
module nib_gap #(
  parameter int GAP_CYCLES = 10,
  localparam int CW = $clog2(GAP_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= CW'(GAP_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(GAP_CYCLES)); // R5
  AST_LOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o); // R5
endmodule

// File: rtl/nib_err.sv
module nib_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_o <= 1'b0;
    else if (set_i) err_o <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
endmodule

// File: rtl/nib_host_if.sv
module nib_host_if
  import nib_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int GAP_CYCLES = 10,
  localparam int BYTE_W    = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic [NIB_W-1:0]  bus_i,
  output logic [NIB_W-1:0]  bus_o,
  output logic              wr_valid_o,
  output logic              wr_sel_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              proto_err_o
);
  logic             wr_stb;
  logic             phase_hi;
  logic [NIB_W-1:0] hi_nib;
  reg_sel_e         sel;
  logic             byte_done;

  assign wr_stb = strobe_i && !rw_i;

  nib_phase #(.NIB_W(NIB_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb),
    .rs_i       (rs_i),
    .nib_i      (bus_i),
    .phase_hi_o (phase_hi),
    .hi_nib_o   (hi_nib),
    .sel_o      (sel),
    .byte_done_o(byte_done)
  );

  nib_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(byte_done),
    .busy_o(busy_o)
  );

  nib_err u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wr_stb && busy_o),
    .err_o (proto_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_sel_o   <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= byte_done;
      if (byte_done) begin
        wr_sel_o  <= sel;
        wr_data_o <= {hi_nib, bus_i};
      end
    end
  end

  // busy flag is meaningful only ahead of an upper half
  always_comb begin
    bus_o = '0;
    if (rw_i && phase_hi) bus_o[NIB_W-1] = busy_o;
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R2
  AST_BUSY_WITH_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> busy_o); // R5
  AST_BUSY_ROSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> wr_valid_o); // R5
  AST_STATUS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_o != '0) |-> (rw_i && busy_o)); // R6
  AST_READ_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proto_err_o && strobe_i && rw_i) |=> !proto_err_o); // R9
endmodule

// File: tb/sim_nib_host_if.sv
module sim_nib_host_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [3:0] bus_in = '0;
  logic [3:0] bus_out;
  logic       wr_valid, wr_sel, busy, perr;
  logic [7:0] wr_data;

  int n_chk = 0, n_bad = 0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  nib_host_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .rs_i(rs), .rw_i(rw),
    .bus_i(bus_in), .bus_o(bus_out), .wr_valid_o(wr_valid), .wr_sel_o(wr_sel),
    .wr_data_o(wr_data), .busy_o(busy), .proto_err_o(perr)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per write pulse
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected pulse", {wr_sel, wr_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({wr_sel, wr_data} == e, "R2/R4 byte", {wr_sel, wr_data}, e);
      end
    end
  end

  task automatic nib(input logic r, input logic [3:0] d);
    @(negedge clk); strobe = 1'b1; rw = 1'b0; rs = r; bus_in = d;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic put_byte(input logic r_hi, input logic r_lo, input logic [7:0] b);
    exp_q.push_back({r_hi, b});
    nib(r_hi, b[7:4]);
    nib(r_lo, b[3:0]);
  endtask

  task automatic read_stb(output logic [3:0] v);
    @(negedge clk); strobe = 1'b1; rw = 1'b1;
    #1 v = bus_out;
    @(negedge clk); strobe = 1'b0; rw = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] st;
    int hi_cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wr_valid && !busy && !perr && wr_data == 8'h00, "R1 reset outputs",
        {wr_valid, busy, perr, wr_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 instruction byte
    put_byte(1'b0, 1'b0, 8'hA5);
    // R5 busy window length
    hi_cnt = 0;
    while (busy && hi_cnt < 40) begin hi_cnt++; @(negedge clk); end
    chk(hi_cnt == 10, "R5 busy length", hi_cnt, 10);

    // R3 lone upper half: no pulse
    nib(1'b1, 4'h3);
    repeat (3) begin
      chk(!wr_valid, "R3 no pulse after upper half", wr_valid, 0);
      @(negedge clk);
    end
    // R7 read in lower phase returns zero and keeps pending byte
    read_stb(st);
    chk(st == 4'h0, "R7 lower-phase read", st, 0);
    exp_q.push_back({1'b1, 8'h3C});
    nib(1'b0, 4'hC); // R4: rs on lower half ignored, upper had rs=1
    chk(busy, "R5 busy with byte", busy, 1);

    // R6 status read while busy, then R9 no error from reads
    read_stb(st);
    chk(st == 4'h8, "R6 status busy", st, 8);
    read_stb(st);
    chk(!perr, "R9 read while busy", perr, 0);
    wait_idle();
    read_stb(st);
    chk(st == 4'h0, "R6 status idle", st, 0);
    // R6 read did not flip phase: next two writes form one byte
    put_byte(1'b1, 1'b1, 8'h7E);
    wait_idle();
    put_byte(1'b0, 1'b1, 8'h01);
    chk(!perr, "R8 no error when spaced", perr, 0);

    // R8 back-to-back byte while busy: error, byte still delivered
    put_byte(1'b1, 1'b0, 8'hD2);
    chk(perr, "R8 error set", perr, 1);
    hi_cnt = 0;
    while (busy && hi_cnt < 40) begin hi_cnt++; @(negedge clk); end
    chk(hi_cnt == 10, "R5 reloaded window", hi_cnt, 10);
    put_byte(1'b0, 1'b0, 8'hF0);
    wait_idle();
    chk(perr, "R8 error sticky", perr, 1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all bytes delivered", exp_q.size(), 0);

    // R1 reset clears error
    rst_n = 1'b0;
    @(negedge clk);
    chk(!perr && !busy, "R1 reset clears", {perr, busy}, 0);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule